// File: doc/BRIEF.md
# Shared Read-Tag Allocator

This block lives inside a shared endpoint that several independent read channels use. Each channel that wants to issue a memory read request asks for a transaction tag through a valid/ready handshake. All channels draw from one common pool. When a tag is free and a channel is chosen, the block hands it out. It records the tag as in use and stores which channel owns it. Because no range of tags is set aside for any channel, a single channel may hold every tag at once. Adding more channels never reduces what one channel can reach.

Completion headers are presented with their tag and a flag marking the completion that finishes the request. For a tag in use, the block reports the owning channel in the same cycle. A finishing completion returns the tag to the pool. A partial completion leaves the tag held. When several channels ask in the same cycle, a rotating pointer decides which one is served. The tag handed out is always the lowest-numbered free tag.

Top module: `tag_allocator`

## Requirements
- R1: After reset every tag is free and the rotating pointer starts at channel 0, so the first grant to a set of requesting channels goes to channel 0 with tag 0.
- R2: The tag offered on `alloc_tag` is the lowest-numbered free tag, with tags numbered 0 to 2^TAG_W-1, and it is valid in any cycle where a bit of `req_ready` is high.
- R3: At most one bit of `req_ready` is high in a cycle, and only for a channel whose `req_valid` bit is high.
- R4: Among the requesting channels, the search starts at the channel after the one granted most recently, wrapping from NUM_CH-1 to 0.
- R5: While every tag is in use, `req_ready` stays all zero. A tag freed by a completion can be granted in the next cycle.
- R6: A completion with `cpl_last` low keeps its tag in use, so the tag is not granted again.
- R7: A completion with `cpl_last` high on a tag in use frees that tag from the next cycle on.
- R8: For a completion on a tag in use, `cpl_hit` is high in the same cycle and `cpl_owner` gives the channel index that was granted that tag.
- R9: A completion on a tag that is not in use drives `cpl_hit` low and changes no tag state.
- R10: A grant and a release in the same cycle both take effect. The released tag is offered from the next cycle on.
- R11: A single channel can hold all 2^TAG_W tags at the same time, whatever NUM_CH is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CH | Per-channel tag request |
| req_ready | output | NUM_CH | Per-channel grant; a handshake takes the tag on `alloc_tag` |
| alloc_tag | output | TAG_W | Tag granted in this cycle |
| cpl_valid | input | 1 | Completion header present |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| cpl_last | input | 1 | This completion finishes its request |
| cpl_hit | output | 1 | The completion's tag is in use |
| cpl_owner | output | idx_width(NUM_CH) | Channel owning the completion's tag |

## Verification
`req_ready`, `alloc_tag`, `cpl_hit` and `cpl_owner` depend combinationally on the inputs and on the stored state. They are therefore due in the same cycle as the stimulus. A grant or a release changes the stored state at the next rising edge, so its effect first shows one cycle later. The bench applies inputs on the falling edge and compares outputs against its reference model 1 ns later. It advances the model only after the rising edge. This way every check on a grant or release lands in the cycle after it, and every same-cycle result is checked in its own cycle.

// File: rtl/tag_alloc_pkg.sv
package tag_alloc_pkg;

    // Width of an index able to address n items, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tag_rr_arbiter.sv
module tag_rr_arbiter #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W = tag_alloc_pkg::idx_width(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   start,
    output logic [NUM_CH-1:0] gnt,
    output logic [CH_W-1:0]   gnt_idx,
    output logic              gnt_any
);

    always_comb begin
        int unsigned pos;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        pos     = 0;
        for (int k = 0; k < NUM_CH; k++) begin
            pos = int'(start) + k;
            if (pos >= NUM_CH) begin
                pos = pos - NUM_CH;
            end
            if (!gnt_any && req[CH_W'(pos)]) begin
                gnt_any             = 1'b1;
                gnt[CH_W'(pos)]     = 1'b1;
                gnt_idx             = CH_W'(pos);
            end
        end
    end

endmodule

// File: rtl/tag_free_finder.sv
module tag_free_finder #(
    parameter int unsigned TAG_W = 5,
    localparam int unsigned NT = 1 << TAG_W
) (
    input  logic [NT-1:0]    in_use,
    output logic [TAG_W-1:0] free_idx,
    output logic             free_any
);

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int t = NT - 1; t >= 0; t--) begin
            if (!in_use[TAG_W'(t)]) begin
                free_idx = TAG_W'(t);
                free_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tag_owner_table.sv
module tag_owner_table #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned TAG_W  = 5,
    localparam int unsigned CH_W = tag_alloc_pkg::idx_width(NUM_CH),
    localparam int unsigned NT   = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [CH_W-1:0]   rd_ch
);

    logic [CH_W-1:0] owner_d [NT];
    logic [CH_W-1:0] owner_q [NT];

    for (genvar g = 0; g < NT; g++) begin : g_entry
        always_comb begin
            owner_d[g] = owner_q[g];
            if (wr_en && (wr_tag == TAG_W'(g))) begin
                owner_d[g] = wr_ch;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                owner_q[g] <= '0;
            end else begin
                owner_q[g] <= owner_d[g];
            end
        end
    end

    assign rd_ch = owner_q[rd_tag];

endmodule

// File: rtl/tag_allocator.sv
module tag_allocator #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned TAG_W  = 5,
    localparam int unsigned CH_W = tag_alloc_pkg::idx_width(NUM_CH),
    localparam int unsigned NT   = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_valid,
    output logic [NUM_CH-1:0] req_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic              cpl_last,
    output logic              cpl_hit,
    output logic [CH_W-1:0]   cpl_owner
);

    typedef struct packed {
        logic [NT-1:0]   in_use;
        logic [CH_W-1:0] rr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0] arb_gnt;
    logic [CH_W-1:0]   arb_idx;
    logic              arb_any;
    logic [TAG_W-1:0]  free_idx;
    logic              free_any;
    logic              grant_fire;
    logic              release_fire;

    tag_rr_arbiter #(.NUM_CH(NUM_CH)) i_arb (
        .req     (req_valid),
        .start   (st_q.rr),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .gnt_any (arb_any)
    );

    tag_free_finder #(.TAG_W(TAG_W)) i_free (
        .in_use   (st_q.in_use),
        .free_idx (free_idx),
        .free_any (free_any)
    );

    tag_owner_table #(.NUM_CH(NUM_CH), .TAG_W(TAG_W)) i_owner (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (grant_fire),
        .wr_tag (free_idx),
        .wr_ch  (arb_idx),
        .rd_tag (cpl_tag),
        .rd_ch  (cpl_owner)
    );

    always_comb begin
        st_d         = st_q;
        grant_fire   = arb_any && free_any;
        req_ready    = free_any ? arb_gnt : '0;
        alloc_tag    = free_idx;
        cpl_hit      = cpl_valid && st_q.in_use[cpl_tag];
        release_fire = cpl_hit && cpl_last;

        if (release_fire) begin
            st_d.in_use[cpl_tag] = 1'b0;
        end
        if (grant_fire) begin
            st_d.in_use[free_idx] = 1'b1;
            st_d.rr = (arb_idx == CH_W'(NUM_CH - 1)) ? '0 : arb_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a single grant, always to a requester
    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

    // R2: the offered tag is not already held
    p_tag_was_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> !st_q.in_use[alloc_tag]);

    // R5: an exhausted pool blocks every requester
    p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.in_use) |-> (req_ready == '0));

    // R10: a granted tag is held in the following cycle
    p_grant_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |=> st_q.in_use[$past(alloc_tag)]);

    // R6: a partial completion keeps its tag
    p_partial_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_last && st_q.in_use[cpl_tag]) |=> st_q.in_use[$past(cpl_tag)]);

    // R7: a finishing completion frees its tag
    p_last_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_last && st_q.in_use[cpl_tag]) |=> !st_q.in_use[$past(cpl_tag)]);

    // R9: a completion on an idle tag leaves it idle unless granted meanwhile
    p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !st_q.in_use[cpl_tag] && !((req_ready != '0) && alloc_tag == cpl_tag))
        |=> !st_q.in_use[$past(cpl_tag)]);

endmodule

// File: tb/test_tag_allocator.sv
`timescale 1ns/1ps
module test_tag_allocator;

    localparam int NCH = 4;
    localparam int TW  = 5;
    localparam int NT  = 1 << TW;
    localparam int CW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req_valid = '0;
    logic [NCH-1:0] req_ready;
    logic [TW-1:0]  alloc_tag;
    logic           cpl_valid = 1'b0;
    logic [TW-1:0]  cpl_tag = '0;
    logic           cpl_last = 1'b0;
    logic           cpl_hit;
    logic [CW-1:0]  cpl_owner;

    int checks = 0;
    int errors = 0;
    int m_busy [NT];
    int m_owner [NT];
    int m_rr = 0;
    int last_tag;

    always #2 clk = ~clk;

    tag_allocator #(.NUM_CH(NCH), .TAG_W(TW)) i_tag_allocator (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .alloc_tag (alloc_tag),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .cpl_last  (cpl_last),
        .cpl_hit   (cpl_hit),
        .cpl_owner (cpl_owner)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic [NCH-1:0] v, input bit cv, input int ct,
                        input bit cl, input string rq);
        int fidx;
        int win;
        logic [NCH-1:0] er;
        bit eh;
        @(negedge clk);
        req_valid = v;
        cpl_valid = cv;
        cpl_tag   = TW'(ct);
        cpl_last  = cl;
        #1;
        fidx = -1;
        for (int t = NT - 1; t >= 0; t--) if (m_busy[t] == 0) fidx = t;
        win = -1;
        if (fidx >= 0) begin
            for (int k = 0; k < NCH; k++) begin
                int i;
                i = (m_rr + k) % NCH;
                if (win < 0 && v[i]) win = i;
            end
        end
        er = '0;
        if (win >= 0) er[win] = 1'b1;
        check(req_ready == er, rq, "ready", int'(req_ready), int'(er));
        if (win >= 0) check(int'(alloc_tag) == fidx, rq, "tag", int'(alloc_tag), fidx);
        eh = cv && (m_busy[ct] != 0);
        check(cpl_hit == eh, rq, "hit", int'(cpl_hit), int'(eh));
        if (eh) check(int'(cpl_owner) == m_owner[ct], rq, "owner", int'(cpl_owner), m_owner[ct]);
        last_tag = (win >= 0) ? fidx : -1;
        @(posedge clk);
        if (eh && cl) m_busy[ct] = 0;
        if (win >= 0) begin
            m_busy[fidx]  = 1;
            m_owner[fidx] = win;
            m_rr = (win + 1) % NCH;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_busy[t] = 0;
            m_owner[t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: first grant goes to channel 0 with tag 0
        step('0, 0, 0, 0, "R1");
        step(4'b1111, 0, 0, 0, "R1");
        check(last_tag == 0, "R1", "first tag", last_tag, 0);

        // R11: one channel takes every remaining tag
        for (int n = 1; n < NT; n++) step(4'b0100, 0, 0, 0, "R11");
        check(m_busy[NT-1] == 1, "R11", "last tag held", m_busy[NT-1], 1);

        // R5: pool empty blocks all channels
        for (int n = 0; n < 3; n++) step(4'b1111, 0, 0, 0, "R5");

        // R6 / R8: partial completion reports owner and keeps tag
        step(4'b1111, 1, 5, 0, "R8");
        step(4'b1111, 0, 0, 0, "R6");

        // R7 / R5: final completion frees tag, granted next cycle
        step(4'b1111, 1, 5, 1, "R7");
        step(4'b1111, 0, 0, 0, "R5");
        check(last_tag == 5, "R5", "refill tag", last_tag, 5);

        // R10: grant and release in one cycle
        step('0, 1, 9, 1, "R10");
        step(4'b0010, 1, 7, 1, "R10");
        check(last_tag == 9, "R10", "same-cycle grant", last_tag, 9);
        step(4'b0010, 0, 0, 0, "R10");
        check(last_tag == 7, "R10", "freed tag reused", last_tag, 7);

        // R9: completion to an idle tag is ignored
        step('0, 1, 12, 1, "R9");
        step('0, 1, 12, 1, "R9");
        step('0, 1, 12, 0, "R9");
        step(4'b1000, 0, 0, 0, "R9");
        check(last_tag == 12, "R9", "idle tag stays free", last_tag, 12);

        // R4: rotation across all requesters
        for (int t = 0; t < 16; t++) step('0, 1, t, 1, "R7");
        for (int n = 0; n < 8; n++) step(4'b1111, 0, 0, 0, "R4");
        for (int n = 0; n < 4; n++) step(4'b1010, 0, 0, 0, "R4");

        // R2 / R3: random traffic
        for (int n = 0; n < 3000; n++) begin
            step(NCH'($urandom), bit'($urandom % 2), int'($urandom % NT),
                 bit'($urandom % 2), "R2");
        end

        finish_run();
    end

endmodule